// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This block resolves read-after-write data hazards in a five-stage in-order integer pipeline: fetch, decode, execute, memory, writeback. The pipeline core feeds it the register numbers held in each of its stage buffers. The block returns four things: the select codes and the resolved data of the two ALU operand multiplexers, a single stall line, and the decode-stage register reads. The register reads come from a register file that lives inside the block.

Each operand multiplexer chooses among three values. The first is the register value latched into the decode/execute buffer. The second is the result in the execute/memory buffer. The third is the value in the memory/writeback buffer, which is also the write data of the register file. A register-file write is visible to a read in the same cycle, so a consumer three slots behind its producer needs no forwarding. With forwarding enabled, only a load followed at once by a dependent instruction must wait one cycle. Forwarding can be disabled by a parameter. In that mode every dependence is resolved by stalling. While `stall` is high, the pipeline core holds the PC and the fetch/decode buffer and loads a bubble (write-enable clear) into the decode/execute buffer. A decoder presents any source field it does not use as register 0.

Top module: `fwd_hazard_unit`

## Requirements
- R1: `fwd_sel_a`/`fwd_sel_b` encode the operand source: 2'b00 the register value from the decode/execute buffer, 2'b01 `mem_data`, 2'b10 `wb_data`. The code 2'b11 never appears. `op_a`/`op_b` equal the selected value.
- R2: When both the execute/memory and memory/writeback buffers write the register an operand reads, the execute/memory value (2'b01) is chosen.
- R3: A producer whose write-enable is low never causes forwarding or a stall, even when its destination number matches.
- R4: Register 0 reads as zero, ignores writes, never matches for forwarding and never causes a stall.
- R5: A register-file write in a cycle is returned by a decode read of the same register in that same cycle, and by later reads.
- R6: With forwarding enabled, `stall` is high exactly when the execute-stage instruction is a load with write-enable set and a nonzero destination equal to a decode source. A dependent instruction right after a load therefore waits one cycle.
- R7: With forwarding enabled, a non-load producer immediately followed by a consumer causes no stall, and the consumer gets the value through select 2'b01.
- R8: With `FWD_EN` = 0, both selects stay 2'b00. `stall` is high while a decode source matches a writing destination in the execute or memory stage. This gives two stall cycles for an adjacent dependence and one stall cycle for a producer two slots ahead.
- R9: After reset every register reads as zero.
- R10: A consumer three slots behind its producer needs neither a stall nor a forwarding path in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the register file |
| id_rs1 | input | AW | Decode-stage first source register |
| id_rs2 | input | AW | Decode-stage second source register |
| id_rdata1 | output | XLEN | Register-file read for id_rs1 |
| id_rdata2 | output | XLEN | Register-file read for id_rs2 |
| ex_rs1 | input | AW | Execute-stage first source register |
| ex_rs2 | input | AW | Execute-stage second source register |
| ex_rd | input | AW | Execute-stage destination register |
| ex_we | input | 1 | Execute-stage register write-enable |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_rf_a | input | XLEN | First operand value latched at decode |
| ex_rf_b | input | XLEN | Second operand value latched at decode |
| mem_rd | input | AW | Execute/memory buffer destination |
| mem_we | input | 1 | Execute/memory buffer write-enable |
| mem_data | input | XLEN | Result held in the execute/memory buffer |
| wb_rd | input | AW | Memory/writeback buffer destination, register-file write address |
| wb_we | input | 1 | Memory/writeback buffer write-enable |
| wb_data | input | XLEN | Memory/writeback value, register-file write data |
| fwd_sel_a | output | 2 | First operand multiplexer select |
| fwd_sel_b | output | 2 | Second operand multiplexer select |
| op_a | output | XLEN | Resolved first ALU operand |
| op_b | output | XLEN | Resolved second ALU operand |
| stall | output | 1 | Hold PC and fetch/decode, bubble into execute |

## Verification
The bench builds two copies side by side with 32 registers of 32 bits. One copy has `FWD_EN` = 1 and the other `FWD_EN` = 0, and both run the same dependence sequences against one behavioural pipeline model. The forwarding copy exercises the execute/memory and memory/writeback paths, their priority and the one-cycle load-use bubble. The copy without forwarding exercises the two-cycle and one-cycle interlocks, and shows that the same-cycle register-file bypass alone delivers correct operands once the stalls have run out.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   // operand multiplexer source codes
   typedef enum logic [1:0] {
      SEL_RF  = 2'b00,
      SEL_MEM = 2'b01,
      SEL_WB  = 2'b10
   } fwd_sel_e;
endpackage

// File: rtl/fwd_regfile.sv
module fwd_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int AW  = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   ra1,
   input  logic [AW-1:0]   ra2,
   output logic [XLEN-1:0] rd1,
   output logic [XLEN-1:0] rd2,
   input  logic            we,
   input  logic [AW-1:0]   wa,
   input  logic [XLEN-1:0] wd
);
   logic [XLEN-1:0] regs [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign regs[i] = '0;
      end else begin : g_store
         logic [XLEN-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (we && wa == AW'(i))
               q <= wd;
         end
         assign regs[i] = q;
      end
   end

   // write-first: a same-cycle write is seen by the read
   always_comb begin
      rd1 = (we && wa == ra1 && ra1 != '0) ? wd : regs[ra1];
      rd2 = (we && wa == ra2 && ra2 != '0) ? wd : regs[ra2];
   end
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
   import fwd_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int AW     = 5,
   parameter bit FWD_EN = 1'b1
) (
   input  logic [AW-1:0]   src,
   input  logic [XLEN-1:0] rf_val,
   input  logic [AW-1:0]   mem_rd,
   input  logic            mem_we,
   input  logic [XLEN-1:0] mem_data,
   input  logic [AW-1:0]   wb_rd,
   input  logic            wb_we,
   input  logic [XLEN-1:0] wb_data,
   output logic [1:0]      sel,
   output logic [XLEN-1:0] val
);
   fwd_sel_e pick;

   if (FWD_EN) begin : g_fwd
      logic hit_mem, hit_wb;
      assign hit_mem = mem_we && (mem_rd == src) && (src != '0);
      assign hit_wb  = wb_we  && (wb_rd  == src) && (src != '0);
      // younger result wins
      always_comb begin
         if (hit_mem)     pick = SEL_MEM;
         else if (hit_wb) pick = SEL_WB;
         else             pick = SEL_RF;
      end
      always_comb begin
         unique case (pick)
            SEL_MEM: val = mem_data;
            SEL_WB:  val = wb_data;
            default: val = rf_val;
         endcase
      end
   end else begin : g_nofwd
      assign pick = SEL_RF;
      assign val  = rf_val;
   end

   assign sel = pick;
endmodule

// File: rtl/fwd_interlock.sv
module fwd_interlock #(
   parameter int AW = 5
) (
   input  logic [AW-1:0] id_rs1,
   input  logic [AW-1:0] id_rs2,
   input  logic [AW-1:0] ex_rd,
   input  logic          ex_blk,
   input  logic [AW-1:0] mem_rd,
   input  logic          mem_blk,
   output logic          stall
);
   // a producer "blocks" when its value cannot yet reach execute
   function automatic logic dep(input logic [AW-1:0] rd, input logic blk,
                                input logic [AW-1:0] a, input logic [AW-1:0] b);
      return blk && (rd != '0) && (rd == a || rd == b);
   endfunction

   assign stall = dep(ex_rd, ex_blk, id_rs1, id_rs2)
                | dep(mem_rd, mem_blk, id_rs1, id_rs2);
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
   parameter int XLEN   = 32,
   parameter int NREG   = 32,
   parameter bit FWD_EN = 1'b1,
   localparam int AW    = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   id_rs1,
   input  logic [AW-1:0]   id_rs2,
   output logic [XLEN-1:0] id_rdata1,
   output logic [XLEN-1:0] id_rdata2,
   input  logic [AW-1:0]   ex_rs1,
   input  logic [AW-1:0]   ex_rs2,
   input  logic [AW-1:0]   ex_rd,
   input  logic            ex_we,
   input  logic            ex_load,
   input  logic [XLEN-1:0] ex_rf_a,
   input  logic [XLEN-1:0] ex_rf_b,
   input  logic [AW-1:0]   mem_rd,
   input  logic            mem_we,
   input  logic [XLEN-1:0] mem_data,
   input  logic [AW-1:0]   wb_rd,
   input  logic            wb_we,
   input  logic [XLEN-1:0] wb_data,
   output logic [1:0]      fwd_sel_a,
   output logic [1:0]      fwd_sel_b,
   output logic [XLEN-1:0] op_a,
   output logic [XLEN-1:0] op_b,
   output logic            stall
);
   localparam int NOPS = 2;

   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("fwd_hazard_unit: NREG must be a power of two of at least 2");
   end
   if (XLEN < 1) begin : g_bad_xlen
      $error("fwd_hazard_unit: XLEN must be positive");
   end

   fwd_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .ra1(id_rs1), .ra2(id_rs2), .rd1(id_rdata1), .rd2(id_rdata2),
      .we(wb_we), .wa(wb_rd), .wd(wb_data)
   );

   logic [AW-1:0]   src   [NOPS];
   logic [XLEN-1:0] rfv   [NOPS];
   logic [XLEN-1:0] opv   [NOPS];
   logic [1:0]      selv  [NOPS];

   assign src[0] = ex_rs1;
   assign src[1] = ex_rs2;
   assign rfv[0] = ex_rf_a;
   assign rfv[1] = ex_rf_b;

   for (genvar g = 0; g < NOPS; g++) begin : g_op
      fwd_operand_sel #(.XLEN(XLEN), .AW(AW), .FWD_EN(FWD_EN)) u_sel (
         .src(src[g]), .rf_val(rfv[g]),
         .mem_rd(mem_rd), .mem_we(mem_we), .mem_data(mem_data),
         .wb_rd(wb_rd), .wb_we(wb_we), .wb_data(wb_data),
         .sel(selv[g]), .val(opv[g])
      );
   end

   assign fwd_sel_a = selv[0];
   assign fwd_sel_b = selv[1];
   assign op_a      = opv[0];
   assign op_b      = opv[1];

   logic ex_blk, mem_blk;
   if (FWD_EN) begin : g_blk_fwd
      assign ex_blk  = ex_we & ex_load;
      assign mem_blk = 1'b0;
   end else begin : g_blk_nofwd
      assign ex_blk  = ex_we;
      assign mem_blk = mem_we;
   end

   fwd_interlock #(.AW(AW)) u_lock (
      .id_rs1(id_rs1), .id_rs2(id_rs2),
      .ex_rd(ex_rd), .ex_blk(ex_blk),
      .mem_rd(mem_rd), .mem_blk(mem_blk),
      .stall(stall)
   );
endmodule

// File: rtl/fwd_hazard_chk.sv
module fwd_hazard_chk #(
   parameter int XLEN   = 32,
   parameter int NREG   = 32,
   parameter bit FWD_EN = 1'b1,
   localparam int AW    = $clog2(NREG)
) (
   input logic            clk,
   input logic            rst_n,
   input logic [AW-1:0]   id_rs1,
   input logic [XLEN-1:0] id_rdata1,
   input logic [AW-1:0]   ex_rs1,
   input logic [XLEN-1:0] ex_rf_a,
   input logic            ex_we,
   input logic            ex_load,
   input logic [AW-1:0]   mem_rd,
   input logic            mem_we,
   input logic [XLEN-1:0] mem_data,
   input logic [AW-1:0]   wb_rd,
   input logic            wb_we,
   input logic [XLEN-1:0] wb_data,
   input logic [1:0]      fwd_sel_a,
   input logic [1:0]      fwd_sel_b,
   input logic [XLEN-1:0] op_a,
   input logic            stall
);
   p_sel_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_sel_a != 2'b11 && fwd_sel_b != 2'b11);

   p_op_mem_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_sel_a == 2'b01 |-> op_a == mem_data);

   p_no_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we && !wb_we) |-> fwd_sel_a == 2'b00);

   p_x0_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ex_rs1 == '0 |-> (fwd_sel_a == 2'b00 && op_a == ex_rf_a));

   p_x0_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      id_rs1 == '0 |-> id_rdata1 == '0);

   p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_we && wb_rd == id_rs1 && id_rs1 != '0) |-> id_rdata1 == wb_data);

   if (FWD_EN) begin : g_fwd
      p_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (mem_we && mem_rd == ex_rs1 && ex_rs1 != '0) |-> fwd_sel_a == 2'b01);

      p_stall_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
         stall |-> (ex_load && ex_we));
   end else begin : g_nofwd
      p_sel_rf_r8: assert property (@(posedge clk) disable iff (!rst_n)
         fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00);
   end
endmodule

bind fwd_hazard_unit fwd_hazard_chk #(.XLEN(XLEN), .NREG(NREG), .FWD_EN(FWD_EN)) u_chk (
   .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rdata1(id_rdata1),
   .ex_rs1(ex_rs1), .ex_rf_a(ex_rf_a), .ex_we(ex_we), .ex_load(ex_load),
   .mem_rd(mem_rd), .mem_we(mem_we), .mem_data(mem_data),
   .wb_rd(wb_rd), .wb_we(wb_we), .wb_data(wb_data),
   .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .op_a(op_a), .stall(stall)
);

// File: tb/tb_fwd_hazard_unit.sv
module tb_fwd_hazard_unit;
   localparam int XLEN = 32;
   localparam int NREG = 32;
   localparam int AW   = 5;

   typedef struct {
      logic [AW-1:0]   rd, rs1, rs2;
      logic            we, ld;
      logic [XLEN-1:0] tag, ea, eb, ra, rb;
   } ins_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [AW-1:0]   id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
   logic            ex_we, ex_load, mem_we, wb_we;
   logic [XLEN-1:0] ex_rf_a, ex_rf_b, mem_data, wb_data;

   logic [XLEN-1:0] f_rd1, f_rd2, f_opa, f_opb, n_rd1, n_rd2, n_opa, n_opb;
   logic [1:0]      f_sa, f_sb, n_sa, n_sb;
   logic            f_st, n_st;

   fwd_hazard_unit #(.XLEN(XLEN), .NREG(NREG), .FWD_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
      .id_rdata1(f_rd1), .id_rdata2(f_rd2),
      .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we),
      .ex_load(ex_load), .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
      .mem_rd(mem_rd), .mem_we(mem_we), .mem_data(mem_data),
      .wb_rd(wb_rd), .wb_we(wb_we), .wb_data(wb_data),
      .fwd_sel_a(f_sa), .fwd_sel_b(f_sb), .op_a(f_opa), .op_b(f_opb), .stall(f_st)
   );

   fwd_hazard_unit #(.XLEN(XLEN), .NREG(NREG), .FWD_EN(1'b0)) dut_nofwd (
      .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
      .id_rdata1(n_rd1), .id_rdata2(n_rd2),
      .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we),
      .ex_load(ex_load), .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
      .mem_rd(mem_rd), .mem_we(mem_we), .mem_data(mem_data),
      .wb_rd(wb_rd), .wb_we(wb_we), .wb_data(wb_data),
      .fwd_sel_a(n_sa), .fwd_sel_b(n_sb), .op_a(n_opa), .op_b(n_opb), .stall(n_st)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit mode_fwd;
   ins_t s_id, s_ex, s_mem, s_wb;
   ins_t prog[$];
   logic [XLEN-1:0] golden [NREG];
   logic [XLEN-1:0] next_tag = 32'hA000_0001;

   task automatic chk(input bit ok, input string req, input logic [XLEN-1:0] act,
                      input logic [XLEN-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s mode_fwd=%0d actual=%h expected=%h t=%0t", req, mode_fwd, act, exp, $time);
      end
   endtask

   function automatic ins_t nop();
      ins_t n;
      n.rd = '0; n.rs1 = '0; n.rs2 = '0; n.we = 1'b0; n.ld = 1'b0;
      n.tag = '0; n.ea = '0; n.eb = '0; n.ra = '0; n.rb = '0;
      return n;
   endfunction

   task automatic push(input int rd, input int rs1, input int rs2, input bit we, input bit ld);
      ins_t n = nop();
      n.rd = AW'(rd); n.rs1 = AW'(rs1); n.rs2 = AW'(rs2); n.we = we; n.ld = ld;
      n.tag = next_tag;
      next_tag = next_tag + 32'h11;
      prog.push_back(n);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         fails++;
         $display("FAIL R6 watchdog actual=%0d expected<20000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   function automatic logic [1:0] exp_sel(input logic [AW-1:0] s);
      if (!mode_fwd || s == '0) return 2'b00;
      if (s_mem.we && s_mem.rd == s) return 2'b01;
      if (s_wb.we && s_wb.rd == s) return 2'b10;
      return 2'b00;
   endfunction

   function automatic bit hits(input ins_t p, input ins_t c);
      return p.we && p.rd != '0 && (p.rd == c.rs1 || p.rd == c.rs2);
   endfunction

   int stall_cnt;

   task automatic step();
      logic st, es;
      logic [1:0] sa, sb;
      logic [XLEN-1:0] oa, ob, r1, r2;
      @(negedge clk);
      id_rs1 = s_id.rs1; id_rs2 = s_id.rs2;
      ex_rs1 = s_ex.rs1; ex_rs2 = s_ex.rs2; ex_rd = s_ex.rd; ex_we = s_ex.we;
      ex_load = s_ex.ld; ex_rf_a = s_ex.ra; ex_rf_b = s_ex.rb;
      mem_rd = s_mem.rd; mem_we = s_mem.we; mem_data = s_mem.tag;
      wb_rd = s_wb.rd; wb_we = s_wb.we; wb_data = s_wb.tag;
      #1;
      if (mode_fwd) begin st = f_st; sa = f_sa; sb = f_sb; oa = f_opa; ob = f_opb; r1 = f_rd1; r2 = f_rd2; end
      else          begin st = n_st; sa = n_sa; sb = n_sb; oa = n_opa; ob = n_opb; r1 = n_rd1; r2 = n_rd2; end
      // expected interlock, from the requirement text
      if (mode_fwd) es = s_ex.ld && hits(s_ex, s_id);           // R6
      else          es = hits(s_ex, s_id) || hits(s_mem, s_id); // R8
      chk(st == es, "R6/R8 stall", XLEN'(st), XLEN'(es));
      chk(sa == exp_sel(s_ex.rs1), "R1 sel_a", XLEN'(sa), XLEN'(exp_sel(s_ex.rs1)));
      chk(sb == exp_sel(s_ex.rs2), "R1 sel_b", XLEN'(sb), XLEN'(exp_sel(s_ex.rs2)));
      chk(oa == s_ex.ea, "R5 op_a value", oa, s_ex.ea);
      chk(ob == s_ex.eb, "R5 op_b value", ob, s_ex.eb);
      if (st) stall_cnt++;
      // advance the behavioural pipeline
      s_wb = s_mem;
      s_mem = s_ex;
      if (es) begin
         s_ex = nop();
      end else begin
         s_ex = s_id;
         s_ex.ra = r1; s_ex.rb = r2;
         s_ex.ea = golden[s_id.rs1];
         s_ex.eb = golden[s_id.rs2];
         if (s_id.we && s_id.rd != '0) golden[s_id.rd] = s_id.tag;
         s_id = (prog.size() != 0) ? prog.pop_front() : nop();
      end
   endtask

   task automatic run_seq(input string name, input int exp_f, input int exp_n);
      int e;
      stall_cnt = 0;
      while (prog.size() != 0) step();
      repeat (7) step();
      e = mode_fwd ? exp_f : exp_n;
      chk(stall_cnt == e, name, XLEN'(stall_cnt), XLEN'(e));
   endtask

   initial begin
      for (int pass = 0; pass < 2; pass++) begin
         mode_fwd = (pass == 0);
         rst_n = 1'b0;
         s_id = nop(); s_ex = nop(); s_mem = nop(); s_wb = nop();
         for (int i = 0; i < NREG; i++) golden[i] = '0;
         id_rs1 = 5'd5; id_rs2 = 5'd31;
         ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0; ex_we = 0; ex_load = 0;
         ex_rf_a = '0; ex_rf_b = '0; mem_rd = '0; mem_we = 0; mem_data = '0;
         wb_rd = '0; wb_we = 0; wb_data = '0;
         repeat (3) @(negedge clk);
         rst_n = 1'b1;
         #1;
         // R9: registers cleared by reset
         chk(f_rd1 == '0 && n_rd1 == '0, "R9 reset read r5", f_rd1 | n_rd1, '0);
         chk(f_rd2 == '0 && n_rd2 == '0, "R9 reset read r31", f_rd2 | n_rd2, '0);

         // R7: ALU producer then consumer on both sources
         push(1, 0, 0, 1, 0); push(4, 1, 1, 1, 0);
         run_seq("R7 adjacent ALU count", 0, 2);
         // R6: load then immediate consumer on second source
         push(2, 0, 0, 1, 1); push(3, 8, 2, 1, 0);
         run_seq("R6 load-use count", 1, 2);
         // R1: producer two slots ahead goes through writeback path
         push(3, 0, 0, 1, 0); push(9, 0, 0, 1, 0); push(11, 3, 0, 1, 0);
         run_seq("R1 two-ahead count", 0, 1);
         // R10: producer three slots ahead relies on the register file
         push(4, 0, 0, 1, 0); push(9, 0, 0, 1, 0); push(10, 0, 0, 1, 0); push(12, 4, 4, 1, 0);
         run_seq("R10 three-ahead count", 0, 0);
         // R2: two writers of one register, younger must win
         push(5, 0, 0, 1, 0); push(5, 1, 0, 1, 0); push(13, 5, 5, 1, 0);
         run_seq("R2 priority count", 0, 2);
         // R3: matching destination with write-enable low
         push(6, 1, 0, 0, 0); push(14, 6, 6, 1, 0);
         run_seq("R3 no-write count", 0, 0);
         // R4: load targeting register 0, then consumer of register 0
         push(0, 0, 0, 1, 1); push(15, 0, 0, 1, 0); push(0, 2, 0, 1, 0); push(16, 0, 0, 1, 0);
         run_seq("R4 zero-register count", 0, 0);
         // R6: load two slots ahead needs no interlock when forwarding
         push(7, 0, 0, 1, 1); push(9, 0, 0, 1, 0); push(17, 7, 0, 1, 0);
         run_seq("R6 load two-ahead count", 0, 1);
         // R8: chain of dependents
         push(18, 1, 2, 1, 0); push(19, 18, 0, 1, 1); push(20, 19, 18, 1, 0);
         run_seq("R8 chain count", 1, 4);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule